// File: doc/BRIEF.md
# Descriptor-Driven Configuration Item DMA Engine

This block is a bus master that moves the bytes of firmware configuration items into system memory on request. Software writes the 64-bit memory address of a 16-byte descriptor into a doorbell register. The engine then reads the descriptor, which holds a control word, a length and a destination address, all big-endian. It may switch to a new item and then, depending on the control bits, does one of three things:

- copies item bytes to the destination;
- writes zeros once the item is exhausted;
- only advances the read position.

It reports completion by storing a status word over the descriptor's control word.

The item currently selected and the byte offset into it form a cursor. A simple byte-read port uses the same cursor, so software can mix programmed reads and DMA reads. The item contents are supplied from outside through a lookup interface (key and offset out; present flag, length and byte in).

Memory traffic uses a request/grant master. A request is held until grant. In the grant cycle the read data and the error flag are valid. A word access is big-endian: the byte at the lowest address travels in bits 31:24. A byte write carries its data in bits 7:0.

The controller is a state machine with five states:

- IDLE: waits for a doorbell start. IDLE→FETCH on start.
- FETCH: four word reads at descriptor offsets 0, 4, 8 and 12. FETCH→DECODE after the fourth read. FETCH→STATUS on any read error.
- DECODE: applies the select bit and picks the mode. DECODE→MOVE always.
- MOVE: the transfer loop. MOVE→STATUS when the length is exhausted or a write has failed.
- STATUS: one word write of the status value to descriptor offset 0. STATUS→IDLE on grant.

Top module: `cfgdma_engine`

## Requirements
- R1: A 4-byte doorbell write at offset 0 sets the address register to {data[31:0], 32'h0} and does not start. A 4-byte write at offset 4 ORs data[31:0] into the low half and starts a transfer at the resulting address.
- R2: An 8-byte doorbell write at offset 0 loads the full address and starts. Any other offset/size combination leaves the address register unchanged and starts nothing.
- R3: Starting a transfer clears the doorbell address register, so a later lone offset-4 write starts at exactly the written low value.
- R4: Doorbell read data for offset o and size s in {1,2,4,8} with o+s≤8 is the bytes o..o+s-1 of 0x51454D5520434647 (byte 0 = 0x51), right-aligned and most significant first. Any other combination reads 0.
- R5: While a transfer is in progress (busy high, from the start until the status write is granted), doorbell writes are ignored. The block issues no memory request while idle.
- R6: The descriptor is read as three big-endian fields: control at offset 0, length at offset 4 and destination at offset 8 (upper half) and 12. Control bit 3 (select) loads the key from control bits 31:16 and zeroes the offset.
- R7: Control bit 1 (read) takes priority over bit 2 (skip). With neither bit set, no data moves and the status is 0.
- R8: In read mode, while the cursor is inside the item, each byte at the cursor is written to the destination, and offset and destination each advance by one.
- R9: Once the item is absent or exhausted, read mode writes zero bytes for all of the remaining length, and skip mode drops the remaining length without writing.
- R10: In skip mode inside an item, the offset advances by min(remaining length, remaining item bytes) and nothing is written.
- R11: The status word written back to descriptor offset 0 is 0x00000000 on success and 0x00000001 if a data write failed. The write that failed still consumes its byte, and the transfer stops there.
- R12: If any descriptor read fails, the engine writes only 0x00000001 to descriptor offset 0 and leaves the key and offset untouched.
- R13: After reset the key and offset are 0. When idle, a host select loads the key and zeroes the offset. A host read returns the byte at the cursor (0 outside the item) and advances the offset only inside the item. Both are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| db_wr | input | 1 | Doorbell write strobe |
| db_off | input | 3 | Doorbell byte offset |
| db_size | input | 4 | Doorbell access size in bytes |
| db_wdata | input | 64 | Doorbell write data, right-aligned |
| db_rdata | output | 64 | Doorbell read data (signature slice) |
| sel_wr | input | 1 | Host item select strobe |
| sel_key | input | KEY_W | Host item key |
| rd_en | input | 1 | Host byte read strobe |
| rd_data | output | 8 | Byte at the cursor, 0 outside the item |
| busy | output | 1 | Transfer in progress |
| itm_key | output | KEY_W | Cursor key to item lookup |
| itm_off | output | OFF_W | Cursor offset to item lookup |
| itm_present | input | 1 | Selected key names an existing item |
| itm_len | input | OFF_W | Length of the selected item |
| itm_byte | input | 8 | Item byte at the cursor offset |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (0 = read) |
| mem_word | output | 1 | Word access (1) or byte access (0) |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory grant, completes the request |
| mem_rdata | input | 32 | Memory read data, valid with grant |
| mem_err | input | 1 | Access fault, valid with grant |

## Verification
The bench builds the engine with its default parameters: a 16-bit key and a 32-bit offset. At these widths, control bits 31:16 map one to one onto the key, and item lengths of 0, 3, 4 and 12 bytes are all reachable. The memory responder marks a fault window at 0x8000–0x8FFF. Placing a destination that straddles its lower edge stops a copy after two bytes. Placing a descriptor whose address field lies inside the window triggers the fetch-fault path while the status store still lands. A descriptor above 4 GiB exercises the upper-half doorbell load.

// File: rtl/cfgdma_pkg.sv
`timescale 1ns/1ps
package cfgdma_pkg;
    localparam logic [63:0] SIG_VALUE = 64'h5145_4D55_2043_4647;
    localparam int CB_READ   = 1;
    localparam int CB_SKIP   = 2;
    localparam int CB_SELECT = 3;
    localparam int DESC_WORDS = 4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_DECODE, ST_MOVE, ST_STATUS
    } state_e;

    typedef enum logic [1:0] {
        MV_NONE, MV_READ, MV_SKIP
    } move_e;
endpackage

// File: rtl/cfgdma_doorbell.sv
`timescale 1ns/1ps
module cfgdma_doorbell
    import cfgdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [2:0]  off,
    input  logic [3:0]  size,
    input  logic [63:0] wdata,
    input  logic        busy,
    output logic        start,
    output logic [63:0] start_addr,
    output logic [63:0] rdata
);
    logic [63:0] addr_q, addr_d;
    logic [4:0]  span;
    logic [7:0]  shamt;
    logic [63:0] mask;

    always_comb begin
        addr_d = addr_q;
        start  = 1'b0;
        if (wr && !busy) begin
            if (size == 4'd4 && off == 3'd0) begin
                addr_d = {wdata[31:0], 32'h0};
            end else if (size == 4'd4 && off == 3'd4) begin
                addr_d = addr_q | {32'h0, wdata[31:0]};
                start  = 1'b1;
            end else if (size == 4'd8 && off == 3'd0) begin
                addr_d = wdata;
                start  = 1'b1;
            end
        end
        start_addr = addr_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= start ? '0 : addr_d;
    end

    always_comb begin
        span  = {2'b0, off} + {1'b0, size};
        shamt = {5'd8 - span, 3'b000};
        unique case (size)
            4'd1:    mask = 64'hFF;
            4'd2:    mask = 64'hFFFF;
            4'd4:    mask = 64'hFFFF_FFFF;
            4'd8:    mask = '1;
            default: mask = '0;
        endcase
        rdata = (span <= 5'd8) ? ((SIG_VALUE >> shamt) & mask) : '0;
    end
endmodule

// File: rtl/cfgdma_cursor.sv
`timescale 1ns/1ps
module cfgdma_cursor #(
    parameter int KEY_W = 16,
    parameter int OFF_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             host_sel,
    input  logic [KEY_W-1:0] host_key,
    input  logic             host_rd,
    input  logic             dma_sel,
    input  logic [KEY_W-1:0] dma_key,
    input  logic             dma_adv,
    input  logic [OFF_W-1:0] dma_step,
    input  logic             itm_present,
    input  logic [OFF_W-1:0] itm_len,
    input  logic [7:0]       itm_byte,
    output logic [KEY_W-1:0] key,
    output logic [OFF_W-1:0] off,
    output logic             in_item,
    output logic [7:0]       rd_data
);
    assign in_item = itm_present && (off < itm_len);
    assign rd_data = in_item ? itm_byte : 8'h00;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key <= '0;
            off <= '0;
        end else if (dma_sel) begin
            key <= dma_key;
            off <= '0;
        end else if (dma_adv) begin
            off <= off + dma_step;
        end else if (!busy) begin
            if (host_sel) begin
                key <= host_key;
                off <= '0;
            end else if (host_rd && in_item) begin
                off <= off + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfgdma_fsm.sv
`timescale 1ns/1ps
module cfgdma_fsm
    import cfgdma_pkg::*;
#(
    parameter int KEY_W = 16,
    parameter int OFF_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [63:0]      start_addr,
    input  logic             in_item,
    input  logic [OFF_W-1:0] itm_len,
    input  logic [OFF_W-1:0] cur_off,
    input  logic [7:0]       itm_byte,
    input  logic             mem_gnt,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_err,
    output logic             busy,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_word,
    output logic [63:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    output logic             dma_sel,
    output logic [KEY_W-1:0] dma_key,
    output logic             dma_adv,
    output logic [OFF_W-1:0] dma_step
);
    localparam int IDX_W = $clog2(DESC_WORDS);

    state_e           state;
    move_e            mode;
    logic [63:0]      base, dst;
    logic [31:0]      len;
    logic [IDX_W-1:0] idx;
    logic [15:0]      c_key;
    logic             c_sel, c_rd, c_skip, err;
    logic [OFF_W-1:0] rem, step;

    assign rem  = itm_len - cur_off;
    assign step = (OFF_W'(len) < rem) ? OFF_W'(len) : rem;
    assign busy = (state != ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            mode  <= MV_NONE;
            base  <= '0;
            dst   <= '0;
            len   <= '0;
            idx   <= '0;
            c_key <= '0;
            c_sel <= 1'b0;
            c_rd  <= 1'b0;
            c_skip <= 1'b0;
            err   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    base  <= start_addr;
                    idx   <= '0;
                    err   <= 1'b0;
                    state <= ST_FETCH;
                end
                ST_FETCH: if (mem_gnt) begin
                    if (mem_err) begin
                        err   <= 1'b1;
                        state <= ST_STATUS;
                    end else begin
                        unique case (idx)
                            2'd0: begin
                                c_key  <= mem_rdata[31:16];
                                c_sel  <= mem_rdata[CB_SELECT];
                                c_skip <= mem_rdata[CB_SKIP];
                                c_rd   <= mem_rdata[CB_READ];
                            end
                            2'd1: len <= mem_rdata;
                            2'd2: dst[63:32] <= mem_rdata;
                            default: dst[31:0] <= mem_rdata;
                        endcase
                        idx <= idx + 1'b1;
                        if (idx == IDX_W'(DESC_WORDS - 1)) state <= ST_DECODE;
                    end
                end
                ST_DECODE: begin
                    if (c_rd)        mode <= MV_READ;
                    else if (c_skip) mode <= MV_SKIP;
                    else begin
                        mode <= MV_NONE;
                        len  <= '0;
                    end
                    state <= ST_MOVE;
                end
                ST_MOVE: begin
                    if (len == '0 || err) begin
                        state <= ST_STATUS;
                    end else if (mode == MV_SKIP) begin
                        if (in_item) begin
                            dst <= dst + 64'(step);
                            len <= len - 32'(step);
                        end else begin
                            dst <= dst + 64'(len);
                            len <= '0;
                        end
                    end else if (mem_gnt) begin
                        dst <= dst + 64'd1;
                        len <= len - 32'd1;
                        if (mem_err) err <= 1'b1;
                    end
                end
                ST_STATUS: if (mem_gnt) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_word  = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        dma_sel   = 1'b0;
        dma_key   = KEY_W'(c_key);
        dma_adv   = 1'b0;
        dma_step  = OFF_W'(1);
        unique case (state)
            ST_IDLE: ;
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_word = 1'b1;
                mem_addr = base + (64'(idx) << 2);
            end
            ST_DECODE: dma_sel = c_sel;
            ST_MOVE: if (len != '0 && !err) begin
                if (mode == MV_SKIP) begin
                    dma_adv  = in_item;
                    dma_step = step;
                end else begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = dst;
                    mem_wdata = {24'h0, in_item ? itm_byte : 8'h00};
                    dma_adv   = mem_gnt && in_item;
                end
            end
            ST_STATUS: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_word  = 1'b1;
                mem_addr  = base;
                mem_wdata = {31'h0, err};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cfgdma_engine.sv
`timescale 1ns/1ps
module cfgdma_engine #(
    parameter int KEY_W = 16,
    parameter int OFF_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             db_wr,
    input  logic [2:0]       db_off,
    input  logic [3:0]       db_size,
    input  logic [63:0]      db_wdata,
    output logic [63:0]      db_rdata,
    input  logic             sel_wr,
    input  logic [KEY_W-1:0] sel_key,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    output logic             busy,
    output logic [KEY_W-1:0] itm_key,
    output logic [OFF_W-1:0] itm_off,
    input  logic             itm_present,
    input  logic [OFF_W-1:0] itm_len,
    input  logic [7:0]       itm_byte,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_word,
    output logic [63:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_gnt,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_err
);
    logic             start, in_item, dma_sel, dma_adv;
    logic [63:0]      start_addr;
    logic [KEY_W-1:0] dma_key;
    logic [OFF_W-1:0] dma_step;

    cfgdma_doorbell u_db (
        .clk(clk), .rst_n(rst_n), .wr(db_wr), .off(db_off), .size(db_size),
        .wdata(db_wdata), .busy(busy), .start(start), .start_addr(start_addr),
        .rdata(db_rdata)
    );

    cfgdma_cursor #(.KEY_W(KEY_W), .OFF_W(OFF_W)) u_cur (
        .clk(clk), .rst_n(rst_n), .busy(busy), .host_sel(sel_wr),
        .host_key(sel_key), .host_rd(rd_en), .dma_sel(dma_sel),
        .dma_key(dma_key), .dma_adv(dma_adv), .dma_step(dma_step),
        .itm_present(itm_present), .itm_len(itm_len), .itm_byte(itm_byte),
        .key(itm_key), .off(itm_off), .in_item(in_item), .rd_data(rd_data)
    );

    cfgdma_fsm #(.KEY_W(KEY_W), .OFF_W(OFF_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .in_item(in_item), .itm_len(itm_len), .cur_off(itm_off),
        .itm_byte(itm_byte), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .mem_err(mem_err), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_word(mem_word), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .dma_sel(dma_sel), .dma_key(dma_key), .dma_adv(dma_adv),
        .dma_step(dma_step)
    );
endmodule

// File: rtl/cfgdma_chk.sv
`timescale 1ns/1ps
module cfgdma_chk #(
    parameter int KEY_W = 16,
    parameter int OFF_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             sel_wr,
    input logic             rd_en,
    input logic [KEY_W-1:0] itm_key,
    input logic [OFF_W-1:0] itm_off,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_word,
    input logic [63:0]      mem_addr,
    input logic [31:0]      mem_wdata,
    input logic             mem_gnt
);
    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R6
    fetch_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_req && mem_word && !mem_we));

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    // R11
    status_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_word) |-> (mem_wdata[31:1] == 31'h0));

    // R13
    cursor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !sel_wr && !rd_en) |=> ($stable(itm_key) && $stable(itm_off)));
endmodule

bind cfgdma_engine cfgdma_chk #(.KEY_W(KEY_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/sim_cfgdma_engine.sv
`timescale 1ns/1ps
module sim_cfgdma_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        db_wr = 1'b0;
    logic [2:0]  db_off = '0;
    logic [3:0]  db_size = '0;
    logic [63:0] db_wdata = '0;
    logic [63:0] db_rdata;
    logic        sel_wr = 1'b0;
    logic [15:0] sel_key = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic        busy;
    logic [15:0] itm_key;
    logic [31:0] itm_off;
    logic        itm_present;
    logic [31:0] itm_len;
    logic [7:0]  itm_byte;
    logic        mem_req, mem_we, mem_word;
    logic [63:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_gnt = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit hold_cmp = 1'b1;
    bit finished = 1'b0;
    int mdl_key = 0;
    int mdl_off = 0;
    logic [7:0] mem [longint unsigned];
    logic [7:0] exp_mem [longint unsigned];

    always #4 clk = ~clk;

    cfgdma_engine u0 (.*);

    function automatic int ilen(int k);
        case (k)
            0: return 4;
            1: return 0;
            2: return 12;
            3: return 3;
            default: return 0;
        endcase
    endfunction
    function automatic bit ipres(int k);
        return k <= 3;
    endfunction
    function automatic logic [7:0] ibyte(int k, int o);
        return 8'(k * 37 + o * 5 + 1);
    endfunction

    assign itm_present = ipres(int'(itm_key));
    assign itm_len     = 32'(ilen(int'(itm_key)));
    assign itm_byte    = ibyte(int'(itm_key), int'(itm_off));

    function automatic bit faulty(longint unsigned a);
        return a >= 64'h8000 && a < 64'h9000;
    endfunction
    function automatic logic [7:0] mget(longint unsigned a);
        return mem.exists(a) ? mem[a] : 8'hEE;
    endfunction
    function automatic logic [7:0] eget(longint unsigned a);
        return exp_mem.exists(a) ? exp_mem[a] : 8'hEE;
    endfunction

    // memory responder: services a request at a falling edge, grants for one cycle
    always @(negedge clk) begin
        if (mem_gnt) begin
            mem_gnt <= 1'b0;
        end else if (mem_req) begin
            automatic bit f = 1'b0;
            automatic int n = mem_word ? 4 : 1;
            automatic logic [31:0] r = '0;
            for (int i = 0; i < n; i++) if (faulty(mem_addr + 64'(i))) f = 1'b1;
            if (!f) begin
                for (int i = 0; i < n; i++) begin
                    if (mem_we) mem[mem_addr + 64'(i)] = mem_word ? mem_wdata[31 - 8*i -: 8] : mem_wdata[7:0];
                    else r = {r[23:0], mget(mem_addr + 64'(i))};
                end
            end
            mem_rdata <= r;
            mem_err   <= f;
            mem_gnt   <= 1'b1;
        end
    end

    task automatic chk(input string tag, input longint unsigned act, input longint unsigned expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // every-clock cursor comparison against the model when idle
    always @(negedge clk) begin
        if (!hold_cmp && !finished) begin
            chk("R13 cursor key", itm_key, 64'(mdl_key));
            chk("R13 cursor off", itm_off, 64'(mdl_off));
            chk("R5 idle busy", busy, 0);
        end
    end

    task automatic chk_mem(input string tag);
        int bad = 0;
        foreach (exp_mem[a]) if (!mem.exists(a) || mem[a] !== exp_mem[a]) bad++;
        foreach (mem[a]) if (!exp_mem.exists(a)) bad++;
        chk(tag, 64'(bad), 0);
    endtask

    task automatic put32(input longint unsigned a, input logic [31:0] v);
        for (int i = 0; i < 4; i++) if (!faulty(a + 64'(i))) begin
            mem[a + 64'(i)] = v[31 - 8*i -: 8];
            exp_mem[a + 64'(i)] = v[31 - 8*i -: 8];
        end
    endtask

    task automatic put_desc(input longint unsigned d, input logic [31:0] c,
                            input logic [31:0] l, input longint unsigned dst);
        put32(d, c);
        put32(d + 4, l);
        put32(d + 8, dst[63:32]);
        put32(d + 12, dst[31:0]);
    endtask

    function automatic logic [31:0] eget32(longint unsigned a);
        return {eget(a), eget(a + 1), eget(a + 2), eget(a + 3)};
    endfunction

    // behavioural model of one descriptor
    task automatic model_desc(input longint unsigned d);
        logic [31:0] c, l;
        longint unsigned dst;
        bit err = 1'b0, ffail = 1'b0;
        for (int i = 0; i < 16; i++) if (faulty(d + 64'(i))) ffail = 1'b1;
        if (!ffail) begin
            c = eget32(d);
            l = eget32(d + 4);
            dst = {eget32(d + 8), eget32(d + 12)};
            if (c[3]) begin mdl_key = int'(c[31:16]); mdl_off = 0; end
            if (!c[1] && !c[2]) l = 0;
            while (l != 0 && !err) begin
                automatic bit inside_item = ipres(mdl_key) && mdl_off < ilen(mdl_key);
                if (c[1]) begin
                    if (faulty(dst)) err = 1'b1;
                    else exp_mem[dst] = inside_item ? ibyte(mdl_key, mdl_off) : 8'h00;
                    if (inside_item) mdl_off++;
                    dst++;
                    l--;
                end else if (!inside_item) begin
                    l = 0;
                end else begin
                    automatic int r = ilen(mdl_key) - mdl_off;
                    automatic int s = (int'(l) < r) ? int'(l) : r;
                    mdl_off += s;
                    l -= 32'(s);
                end
            end
        end else begin
            err = 1'b1;
        end
        for (int i = 0; i < 4; i++)
            if (!faulty(d + 64'(i))) exp_mem[d + 64'(i)] = (i == 3) ? {7'h0, err} : 8'h00;
    endtask

    task automatic db_write(input logic [2:0] o, input logic [3:0] s, input logic [63:0] v);
        @(negedge clk);
        db_wr = 1'b1; db_off = o; db_size = s; db_wdata = v;
        @(negedge clk);
        db_wr = 1'b0;
    endtask

    // how: 0 = 8-byte write, 1 = split write, 2 = low half only
    task automatic xfer(input longint unsigned d, input int how, input bit poke, input string tag);
        hold_cmp = 1'b1;
        model_desc(d);
        if (how == 0) db_write(3'd0, 4'd8, d);
        else begin
            if (how == 1) db_write(3'd0, 4'd4, {32'h0, d[63:32]});
            db_write(3'd4, 4'd4, {32'h0, d[31:0]});
        end
        if (poke) begin
            repeat (3) @(negedge clk);
            db_write(3'd0, 4'd8, 64'h500);
        end
        while (busy) @(negedge clk);
        chk_mem({tag, " memory image"});
        chk({tag, " key"}, itm_key, 64'(mdl_key));
        chk({tag, " off"}, itm_off, 64'(mdl_off));
        hold_cmp = 1'b0;
    endtask

    task automatic host_sel(input int k);
        @(negedge clk);
        sel_wr = 1'b1; sel_key = 16'(k);
        @(posedge clk);
        mdl_key = k; mdl_off = 0;
        @(negedge clk);
        sel_wr = 1'b0;
    endtask

    task automatic host_rd();
        automatic bit inside_item;
        @(negedge clk);
        rd_en = 1'b1;
        inside_item = ipres(mdl_key) && mdl_off < ilen(mdl_key);
        #1 chk("R13 host read data", rd_data, inside_item ? 64'(ibyte(mdl_key, mdl_off)) : 0);
        @(posedge clk);
        if (inside_item) mdl_off++;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic logic [63:0] sig_exp(int o, int s);
        logic [63:0] sig = 64'h5145_4D55_2043_4647;
        logic [63:0] v = '0;
        if (!(s == 1 || s == 2 || s == 4 || s == 8) || o + s > 8) return '0;
        for (int i = o; i < o + s; i++) v = (v << 8) | 64'(sig[63 - 8*i -: 8]);
        return v;
    endfunction

    task automatic sig_read(input int o, input int s);
        @(negedge clk);
        db_off = 3'(o); db_size = 4'(s);
        #1 chk("R4 signature read", db_rdata, sig_exp(o, s));
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13 reset key", itm_key, 0);
        chk("R13 reset off", itm_off, 0);
        chk("R5 reset busy", busy, 0);
        chk("R5 reset req", mem_req, 0);
        hold_cmp = 1'b0;

        // R4
        sig_read(0, 8); sig_read(0, 4); sig_read(4, 4); sig_read(2, 2);
        sig_read(7, 1); sig_read(6, 4); sig_read(0, 3);

        // R13
        host_sel(2);
        host_rd(); host_rd(); host_rd();
        host_sel(5);
        host_rd();

        // R6 R8 R2: select key2, read 5
        put_desc(64'h100, 32'h0002_000A, 32'd5, 64'h1000);
        xfer(64'h100, 0, 1'b0, "R8 copy");
        // R1 R9: split doorbell above 4 GiB, copy tail then zeros
        put_desc(64'h1_0000_0400, 32'h0000_0002, 32'd10, 64'h1100);
        xfer(64'h1_0000_0400, 1, 1'b0, "R1 R9 split read");
        // R3 R10: low-half only write after a start
        put_desc(64'h240, 32'h0003_000C, 32'd2, 64'h1180);
        xfer(64'h240, 2, 1'b0, "R3 R10 skip inside");
        // R9 skip past end
        put_desc(64'h280, 32'h0000_0004, 32'd5, 64'h1200);
        xfer(64'h280, 0, 1'b0, "R9 skip past end");
        // R7 read beats skip
        put_desc(64'h2C0, 32'h0000_000E, 32'd4, 64'h1300);
        xfer(64'h2C0, 0, 1'b0, "R7 read priority");
        // R7 neither bit
        put_desc(64'h300, 32'h0002_0008, 32'd7, 64'h1400);
        xfer(64'h300, 0, 1'b0, "R7 no mode");
        // R9 absent key
        put_desc(64'h340, 32'h0005_000A, 32'd3, 64'h1500);
        xfer(64'h340, 0, 1'b0, "R9 absent key");
        // R9 empty item
        put_desc(64'h380, 32'h0001_000A, 32'd2, 64'h1600);
        xfer(64'h380, 0, 1'b0, "R9 empty item");
        // R11 write fault mid-copy
        put_desc(64'h3C0, 32'h0002_000A, 32'd6, 64'h7FFE);
        xfer(64'h3C0, 0, 1'b0, "R11 write fault");
        // R12 descriptor fetch fault
        put_desc(64'h7FF8, 32'h0003_000A, 32'd4, 64'h1700);
        xfer(64'h7FF8, 0, 1'b0, "R12 fetch fault");
        // R5 doorbell ignored while busy
        put_desc(64'h500, 32'h0000_0004, 32'd0, 64'h0);
        put_desc(64'h440, 32'h0002_000A, 32'd12, 64'h1800);
        xfer(64'h440, 0, 1'b1, "R5 busy ignore");
        // R2 rejected doorbell writes: no start, no address change
        hold_cmp = 1'b1;
        db_write(3'd0, 4'd2, 64'hFFFF);
        db_write(3'd4, 4'd8, 64'h100);
        db_write(3'd2, 4'd4, 64'h100);
        begin
            automatic int seen = 0;
            repeat (10) begin @(negedge clk); if (busy) seen++; end
            chk("R2 rejected write starts nothing", 64'(seen), 0);
        end
        hold_cmp = 1'b0;
        put_desc(64'h5C0, 32'h0000_0004, 32'd0, 64'h0);
        xfer(64'h5C0, 2, 1'b0, "R2 address unchanged");

        repeat (5) @(negedge clk);
        finished = 1'b1;
        summary();
    end
endmodule